// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves 8-bit frames in both directions at once over a data-out line, a data-in line and a shared transfer clock. The host writes a byte into a holding buffer. When the transmitter may run, the byte moves into a shift register and is sent one bit per clock cycle. In the same frame, the receive shift register collects eight incoming bits and then hands them to a receive buffer that the host reads.

The transfer clock comes from one of two places. The block can make it itself, by dividing the system clock by 2·(n+1), or it can take it from an external clock pin. A polarity control picks which edge launches data and which edge samples it. Frames can go out least-significant bit first or most-significant bit first, and the line data can be inverted.

Reception never runs alone. A frame only starts when the transmitter is enabled and has a byte loaded, so a receive-only host writes a dummy byte to get the clock going. The exception is continuous mode: there, reading the receive buffer starts the next frame by itself.

Top module: `csio_unit`

## Requirements
- R1: A frame carries exactly 8 data bits and spans 16 transfer-clock edges. With the internal clock, `sclk_out` is back at its idle level when the frame ends.
- R2: With the internal clock (`clk_ext_sel`=0), each half period of `sclk_out` lasts `div_val`+1 system clocks, so a full period lasts 2·(`div_val`+1).
- R3: The idle clock level is the inverse of `clk_pol`. The launch edge is the one that moves the clock to the `clk_pol` level (falling when `clk_pol`=0) and changes `sdata_out`. The opposite edge samples `sdata_in`.
- R4: A frame that carries host data starts only when all of these hold: `tx_en`=1, the holding buffer is full (`tx_empty`=0), and either `cts_en`=0 or `cts_n`=0. At that start `tx_empty` returns to 1.
- R5: Receive data is captured only if `rx_en`=1 when the frame starts. With `tx_en`=0 no frame runs and nothing is received. With `rx_en`=0, `rx_full` stays 0.
- R6: `tx_irq_sel`=0 pulses `tx_irq` in the cycle the buffer moves into the shifter, before any clock edge. `tx_irq_sel`=1 pulses `tx_irq` when the 16th edge completes the frame.
- R7: `msb_first`=0 sends and assembles bit 0 first. `msb_first`=1 sends and assembles bit 7 first.
- R8: At the end of a receiving frame with no overrun, the byte appears on `rd_data`, `rx_full` becomes 1 and `rx_irq` pulses for one cycle. A `rd_stb` clears `rx_full`.
- R9: If `rx_full` is still 1 at the 7th sampling edge of a frame, `overrun` becomes 1 at that edge. In that frame the buffer keeps its old byte and `rx_irq` does not pulse. A `rd_stb` clears `overrun`.
- R10: `data_inv`=1 inverts every transmitted bit on `sdata_out` and every received bit taken from `sdata_in`. Between frames `sdata_out` rests at 1.
- R11: `rts_n` is 0 exactly when `rx_en`=1 and `rx_full`=0, and is 1 otherwise.
- R12: With `cont_rx`=1, a `rd_stb` that empties a full receive buffer starts a new frame without a buffer write. That frame transmits all ones (before inversion) and leaves `tx_empty` unchanged. With `cont_rx`=0, a read starts nothing.
- R13: If a host write lands in the same cycle as the buffer-to-shifter move, the frame sends the old byte, the buffer keeps the new byte, and `tx_empty` stays 0.
- R14: With `clk_ext_sel`=1, `sclk_oe` is 0 and the edges come from `sclk_in` through a synchronizer. `sclk_in` edges outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| clk_ext_sel | input | 1 | 1 = transfer clock from `sclk_in`, 0 = internal divider |
| clk_pol | input | 1 | Clock polarity (0: launch on falling, sample on rising) |
| msb_first | input | 1 | Bit order select |
| data_inv | input | 1 | Invert line data in both directions |
| cts_en | input | 1 | Gate frame start on `cts_n` |
| cont_rx | input | 1 | Continuous receive mode |
| tx_irq_sel | input | 1 | Transmit interrupt point (0 load, 1 completion) |
| div_val | input | 8 | Divider setting n |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Read strobe for the receive buffer |
| rd_data | output | 8 | Receive buffer contents |
| tx_empty | output | 1 | Holding buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | Overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock output |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sdata_in | input | 1 | Serial data in |
| sdata_out | output | 1 | Serial data out |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The conflict that matters here is a host write in the same cycle that the holding buffer is emptied into the transmit shifter. The bench provokes it by keeping the transmitter disabled while a byte sits in the buffer, then raising `tx_en` and pulsing `wr_stb` with a second byte at the same clock edge. With the line looped back, the scoreboard must see the first byte received and then the second, in that order. It must also see `tx_empty` stay low just after the collision.

// File: rtl/csio_pkg.sv
package csio_pkg;
  typedef enum logic {
    TXI_ON_LOAD = 1'b0,
    TXI_ON_DONE = 1'b1
  } txi_src_e;

  localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             pol,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sclk_in,
  output logic             launch_ev,
  output logic             sample_ev,
  output logic             sclk_out
);
  logic [DIV_W-1:0]       div_cnt_q;
  logic                   sclk_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   tick;
  logic                   ext_lvl;
  logic                   ext_edge;

  // half period of n+1 system clocks
  function automatic logic half_done(input logic [DIV_W-1:0] cnt,
                                     input logic [DIV_W-1:0] n);
    return cnt == n;
  endfunction

  assign tick     = run && !ext_sel && half_done(div_cnt_q, div_val);
  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_edge = ext_lvl != ext_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q  <= '0;
      sclk_q     <= 1'b1;
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q[0] <= sclk_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      ext_prev_q <= ext_lvl;
      if (!run || ext_sel || tick) div_cnt_q <= '0;
      else                         div_cnt_q <= div_cnt_q + 1'b1;
      if (!run)      sclk_q <= ~pol;
      else if (tick) sclk_q <= ~sclk_q;
    end
  end

  // launch edge moves the clock to the pol level
  assign launch_ev = (tick && (sclk_q != pol)) ||
                     (run && ext_sel && ext_edge && (ext_lvl == pol));
  assign sample_ev = (tick && (sclk_q == pol)) ||
                     (run && ext_sel && ext_edge && (ext_lvl != pol));
  assign sclk_out  = sclk_q;
endmodule

// File: rtl/csio_tx.sv
module csio_tx
  import csio_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               start_ev,
  input  logic               load_buf,
  input  logic               launch_ev,
  input  logic               frame_done,
  input  logic               msb_first,
  input  logic               invert,
  output logic               tx_empty,
  output logic               sdata_out
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] hold_q;
  logic [FRAME_W-1:0] shf_q;
  logic [IDX_W-1:0]   idx_q;
  logic               empty_q;
  logic               sdo_q;

  function automatic logic pick_bit(input logic [FRAME_W-1:0] d,
                                    input logic [IDX_W-1:0]   idx,
                                    input logic               msb);
    int pos;
    pos = msb ? (FRAME_W - 1 - int'(idx)) : int'(idx);
    return d[pos];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shf_q   <= '1;
      idx_q   <= '0;
      empty_q <= 1'b1;
      sdo_q   <= LINE_IDLE;
    end else begin
      if (start_ev) begin
        shf_q <= load_buf ? hold_q : '1;
        idx_q <= '0;
      end
      if (wr_stb) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end else if (start_ev && load_buf) begin
        empty_q <= 1'b1;
      end
      if (launch_ev) begin
        sdo_q <= pick_bit(shf_q, idx_q, msb_first) ^ invert;
        idx_q <= idx_q + 1'b1;
      end else if (frame_done) begin
        sdo_q <= LINE_IDLE;
      end
    end
  end

  assign tx_empty  = empty_q;
  assign sdata_out = sdo_q;
endmodule

// File: rtl/csio_rx.sv
module csio_rx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ev,
  input  logic               rx_take,
  input  logic               sample_ev,
  input  logic               ovr_point,
  input  logic               frame_done,
  input  logic               rd_stb,
  input  logic               sdata_in,
  input  logic               msb_first,
  input  logic               invert,
  output logic [FRAME_W-1:0] rx_buf,
  output logic               rx_full,
  output logic               overrun,
  output logic               rx_irq
);
  logic [FRAME_W-1:0] shf_q;
  logic [FRAME_W-1:0] buf_q;
  logic [FRAME_W-1:0] shf_next;
  logic               act_q;
  logic               ovf_q;
  logic               full_q;
  logic               ovr_q;
  logic               irq_q;
  logic               ovr_hit;
  logic               load;

  function automatic logic [FRAME_W-1:0] shift_in(input logic [FRAME_W-1:0] sr,
                                                  input logic               b,
                                                  input logic               msb);
    return msb ? {sr[FRAME_W-2:0], b} : {b, sr[FRAME_W-1:1]};
  endfunction

  assign shf_next = shift_in(shf_q, sdata_in ^ invert, msb_first);
  assign ovr_hit  = ovr_point && act_q && full_q && !rd_stb;
  assign load     = frame_done && act_q && !ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q  <= '0;
      buf_q  <= '0;
      act_q  <= 1'b0;
      ovf_q  <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (start_ev) begin
        act_q <= rx_take;
        ovf_q <= 1'b0;
      end else begin
        if (frame_done) act_q <= 1'b0;
        if (ovr_hit)    ovf_q <= 1'b1;
      end
      if (sample_ev && act_q) shf_q <= shf_next;
      irq_q <= load;
      if (load) begin
        buf_q  <= shf_next;
        full_q <= 1'b1;
      end else if (rd_stb) begin
        full_q <= 1'b0;
      end
      if (ovr_hit)     ovr_q <= 1'b1;
      else if (rd_stb) ovr_q <= 1'b0;
    end
  end

  assign rx_buf  = buf_q;
  assign rx_full = full_q;
  assign overrun = ovr_q;
  assign rx_irq  = irq_q;
endmodule

// File: rtl/csio_unit.sv
module csio_unit
  import csio_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic               clk_ext_sel,
  input  logic               clk_pol,
  input  logic               msb_first,
  input  logic               data_inv,
  input  logic               cts_en,
  input  logic               cont_rx,
  input  logic               tx_irq_sel,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               wr_stb,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_stb,
  output logic [FRAME_W-1:0] rd_data,
  output logic               tx_empty,
  output logic               rx_full,
  output logic               overrun,
  output logic               tx_irq,
  output logic               rx_irq,
  input  logic               sclk_in,
  output logic               sclk_out,
  output logic               sclk_oe,
  input  logic               sdata_in,
  output logic               sdata_out,
  input  logic               cts_n,
  output logic               rts_n
);
  localparam int CNT_W = $clog2(FRAME_W) + 1;

  logic             frame_busy;
  logic [CNT_W-1:0] samp_cnt_q;
  logic             tx_loaded_q;
  logic             cont_arm_q;
  logic             tx_irq_q;
  logic             cts_ok;
  logic             can_tx;
  logic             can_cont;
  logic             start_ev;
  logic             launch_ev;
  logic             sample_ev;
  logic             frame_done;
  logic             ovr_point;
  txi_src_e         txi_src;

  assign txi_src    = txi_src_e'(tx_irq_sel);
  assign cts_ok     = !cts_en || !cts_n;
  assign can_tx     = tx_en && !tx_empty && cts_ok;
  assign can_cont   = tx_en && rx_en && cont_rx && cont_arm_q && cts_ok;
  assign start_ev   = !frame_busy && (can_tx || can_cont);
  assign frame_done = sample_ev && (samp_cnt_q == CNT_W'(FRAME_W - 1));
  assign ovr_point  = sample_ev && (samp_cnt_q == CNT_W'(FRAME_W - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_busy  <= 1'b0;
      samp_cnt_q  <= '0;
      tx_loaded_q <= 1'b0;
      cont_arm_q  <= 1'b0;
      tx_irq_q    <= 1'b0;
    end else begin
      if (start_ev) begin
        frame_busy  <= 1'b1;
        samp_cnt_q  <= '0;
        tx_loaded_q <= can_tx;
      end else begin
        if (frame_done) frame_busy <= 1'b0;
        if (sample_ev)  samp_cnt_q <= samp_cnt_q + 1'b1;
      end
      if (!cont_rx || start_ev)           cont_arm_q <= 1'b0;
      else if (rd_stb && rx_full)         cont_arm_q <= 1'b1;
      tx_irq_q <= (start_ev && can_tx && txi_src == TXI_ON_LOAD) ||
                  (frame_done && tx_loaded_q && txi_src == TXI_ON_DONE);
    end
  end

  csio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (frame_busy),
    .ext_sel   (clk_ext_sel),
    .pol       (clk_pol),
    .div_val   (div_val),
    .sclk_in   (sclk_in),
    .launch_ev (launch_ev),
    .sample_ev (sample_ev),
    .sclk_out  (sclk_out)
  );

  csio_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .start_ev   (start_ev),
    .load_buf   (can_tx),
    .launch_ev  (launch_ev),
    .frame_done (frame_done),
    .msb_first  (msb_first),
    .invert     (data_inv),
    .tx_empty   (tx_empty),
    .sdata_out  (sdata_out)
  );

  csio_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ev   (start_ev),
    .rx_take    (rx_en),
    .sample_ev  (sample_ev),
    .ovr_point  (ovr_point),
    .frame_done (frame_done),
    .rd_stb     (rd_stb),
    .sdata_in   (sdata_in),
    .msb_first  (msb_first),
    .invert     (data_inv),
    .rx_buf     (rd_data),
    .rx_full    (rx_full),
    .overrun    (overrun),
    .rx_irq     (rx_irq)
  );

  assign tx_irq  = tx_irq_q;
  assign sclk_oe = !clk_ext_sel;
  assign rts_n   = !(rx_en && !rx_full);
endmodule

// File: rtl/csio_checker.sv
module csio_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic cts_en,
  input logic cts_n,
  input logic tx_empty,
  input logic rx_full,
  input logic rx_irq,
  input logic overrun,
  input logic rts_n,
  input logic frame_done,
  input logic clk_ext_sel,
  input logic clk_pol,
  input logic sclk_out
);
  AST_RTS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rts_n); // R11

  AST_TX_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> ($past(tx_en) && (!$past(cts_en) || !$past(cts_n)))); // R4

  AST_RXIRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full); // R8

  AST_OVR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !rx_irq); // R9

  AST_DONE_IDLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !clk_ext_sel && $stable(clk_pol)) |=> (sclk_out != clk_pol)); // R1
endmodule

bind csio_unit csio_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .cts_en      (cts_en),
  .cts_n       (cts_n),
  .tx_empty    (tx_empty),
  .rx_full     (rx_full),
  .rx_irq      (rx_irq),
  .overrun     (overrun),
  .rts_n       (rts_n),
  .frame_done  (frame_done),
  .clk_ext_sel (clk_ext_sel),
  .clk_pol     (clk_pol),
  .sclk_out    (sclk_out)
);

// File: tb/csio_unit_tb_top.sv
module csio_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, rx_en, clk_ext_sel, clk_pol, msb_first, data_inv;
  logic       cts_en, cont_rx, tx_irq_sel;
  logic [7:0] div_val;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       drv_rd, mon_rd, rd_stb;
  logic [7:0] rd_data;
  logic       tx_empty, rx_full, overrun, tx_irq, rx_irq;
  logic       sclk_in, sclk_out, sclk_oe;
  logic       sdata_in, sdata_out, drv_sdi, loopback;
  logic       cts_n, rts_n;
  logic       auto_read;

  int checks = 0;
  int errors = 0;
  logic [7:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_stb   = drv_rd | mon_rd;
  assign sdata_in = loopback ? sdata_out : drv_sdi;

  csio_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .clk_ext_sel(clk_ext_sel), .clk_pol(clk_pol), .msb_first(msb_first),
    .data_inv(data_inv), .cts_en(cts_en), .cont_rx(cont_rx),
    .tx_irq_sel(tx_irq_sel), .div_val(div_val), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .cts_n(cts_n), .rts_n(rts_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic host_read();
    drv_rd = 1'b1;
    @(negedge clk);
    drv_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * (int'(div_val) + 1) * 16 + 20) @(negedge clk);
  endtask

  // cycles between two falling edges of sclk_out
  task automatic measure_period(output int cyc);
    logic prev;
    int n;
    prev = sclk_out; n = 0;
    while (!(prev && !sclk_out)) begin prev = sclk_out; @(negedge clk); end
    prev = sclk_out;
    @(negedge clk); n = 1;
    while (!(prev && !sclk_out)) begin prev = sclk_out; @(negedge clk); n++; end
    cyc = n;
  endtask

  // count sclk_out transitions until tx_irq is seen
  task automatic edges_at_txirq(output int cnt);
    logic prev;
    int lim;
    prev = sclk_out; cnt = 0; lim = 0;
    while (!tx_irq && lim < 500) begin
      @(negedge clk);
      if (sclk_out != prev) cnt++;
      prev = sclk_out; lim++;
    end
  endtask

  task automatic ext_frame(input logic [7:0] txd, input logic [7:0] rxd);
    wr_byte(txd);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = clk_pol;
      repeat (6) @(negedge clk);
      chk("R7 R10 R14 launched bit",
          sdata_out, (msb_first ? txd[7-i] : txd[i]) ^ data_inv);
      drv_sdi = (msb_first ? rxd[7-i] : rxd[i]) ^ data_inv;
      sclk_in = ~clk_pol;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    mon_rd = 1'b0;
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (rst_n === 1'b1 && rx_irq === 1'b1) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 R9 unexpected rx_irq actual=%0h expected=none", rd_data);
        end else begin
          chk("R8 received byte", rd_data, sb_q.pop_front());
        end
        if (auto_read) mon_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, cnt;
    logic prev;
    rst_n = 1'b0; tx_en = 0; rx_en = 0; clk_ext_sel = 0; clk_pol = 0;
    msb_first = 0; data_inv = 0; cts_en = 0; cont_rx = 0; tx_irq_sel = 0;
    div_val = 8'd1; wr_stb = 0; wr_data = 0; drv_rd = 0; sclk_in = 1;
    drv_sdi = 1; loopback = 1; cts_n = 1; auto_read = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R4 reset tx_empty", tx_empty, 1);
    chk("R8 reset rx_full", rx_full, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R10 idle data line", sdata_out, 1);
    chk("R3 idle clock pol0", sclk_out, 1);
    chk("R11 rts with rx off", rts_n, 1);
    chk("R14 clock output enabled", sclk_oe, 1);

    // R2 divider
    tx_en = 1; div_val = 8'd3;
    wr_byte(8'h55);
    measure_period(cyc);
    chk("R2 period n=3", cyc, 8);
    settle();
    div_val = 8'd0;
    wr_byte(8'h12);
    measure_period(cyc);
    chk("R2 period n=0", cyc, 2);
    settle();
    div_val = 8'd1;

    // R6 interrupt point and R1 edge count
    tx_irq_sel = 1;
    wr_byte(8'hC3);
    edges_at_txirq(cnt);
    chk("R6 R1 edges at completion irq", cnt, 16);
    chk("R1 clock back to idle", sclk_out, 1);
    settle();
    tx_irq_sel = 0;
    wr_byte(8'h3C);
    edges_at_txirq(cnt);
    chk("R6 no edges at load irq", cnt, 0);
    chk("R4 buffer emptied at load", tx_empty, 1);
    settle();

    // R5 rx off: no capture
    chk("R5 rx off keeps rx_full low", rx_full, 0);

    // loopback scoreboard
    rx_en = 1;
    @(negedge clk);
    chk("R11 rts ready", rts_n, 0);
    sb_q.push_back(8'hA5); wr_byte(8'hA5); settle();
    sb_q.push_back(8'h3C); wr_byte(8'h3C); settle();
    msb_first = 1; data_inv = 1;
    sb_q.push_back(8'h81); wr_byte(8'h81); settle();
    msb_first = 0; data_inv = 0;
    chk("R8 queue drained", sb_q.size(), 0);
    chk("R8 read cleared full", rx_full, 0);

    // R4 R5 tx disabled: no frame
    tx_en = 0;
    wr_byte(8'h77);
    settle();
    chk("R4 R5 no start without tx_en", tx_empty, 0);
    chk("R5 nothing received", rx_full, 0);

    // R13 write colliding with the load
    sb_q.push_back(8'h77); sb_q.push_back(8'hE1);
    tx_en = 1; wr_data = 8'hE1; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
    chk("R13 buffer still full after collision", tx_empty, 0);
    settle(); settle();
    chk("R13 both bytes in order", sb_q.size(), 0);

    // R4 CTS gating
    cts_en = 1; cts_n = 1;
    wr_byte(8'h5A);
    prev = sclk_out; cnt = 0;
    repeat (60) begin @(negedge clk); if (sclk_out != prev) cnt++; prev = sclk_out; end
    chk("R4 held by cts high", tx_empty, 0);
    chk("R4 no clock while held", cnt, 0);
    sb_q.push_back(8'h5A);
    cts_n = 0;
    settle();
    chk("R4 sent after cts low", tx_empty, 1);
    cts_en = 0; cts_n = 1;

    // R9 overrun
    auto_read = 0;
    sb_q.push_back(8'h69); wr_byte(8'h69); settle();
    chk("R11 rts when full", rts_n, 1);
    wr_data = 8'h96; wr_stb = 1;
    prev = sclk_out; cnt = 0;
    @(negedge clk); wr_stb = 0;
    while (!overrun && cnt < 40) begin
      @(negedge clk);
      if (sclk_out != prev) cnt++;
      prev = sclk_out;
    end
    chk("R9 overrun at 7th sample", cnt, 14);
    settle();
    chk("R9 buffer kept", rd_data, 8'h69);
    chk("R9 still full", rx_full, 1);
    host_read();
    chk("R9 read clears overrun", overrun, 0);
    chk("R8 read clears full", rx_full, 0);
    auto_read = 1;

    // R12 continuous receive
    cont_rx = 1;
    sb_q.push_back(8'h5E); sb_q.push_back(8'hFF);
    wr_byte(8'h5E);
    while (sb_q.size() != 1) @(negedge clk);
    repeat (5) @(negedge clk);
    cont_rx = 0;
    while (sb_q.size() != 0) @(negedge clk);
    chk("R12 dummy frame left tx_empty", tx_empty, 1);
    repeat (5) @(negedge clk);
    prev = sclk_out; cnt = 0;
    repeat (60) begin @(negedge clk); if (sclk_out != prev) cnt++; prev = sclk_out; end
    chk("R12 no restart without cont mode", cnt, 0);

    // R14 external clock, pol1, msb first, inverted
    loopback = 0; clk_ext_sel = 1; clk_pol = 1; msb_first = 1; data_inv = 1;
    sclk_in = 0;
    repeat (6) @(negedge clk);
    chk("R14 clock output disabled", sclk_oe, 0);
    sb_q.push_back(8'h4D);
    ext_frame(8'hB2, 8'h4D);
    chk("R10 line idle after frame", sdata_out, 1);
    // pol0, lsb first, plain
    clk_pol = 0; msb_first = 0; data_inv = 0; sclk_in = 1;
    repeat (6) @(negedge clk);
    sb_q.push_back(8'h5A);
    ext_frame(8'h96, 8'h5A);
    repeat (10) @(negedge clk);
    chk("R14 all external bytes seen", sb_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule